// File: doc/BRIEF.md
# Constrained Flag Combination Enumerator

This block produces test stimulus by walking through every setting of a vector of single-bit flags (27 by default). It treats the vector as a binary counter whose least significant position is flag 0. Each request from the consumer moves it to the next setting. Settings that break any of four fixed legality rules are passed over automatically, so the consumer only ever sees legal settings. The block only generates stimulus. It does not apply the flags to anything and it does not judge results.

Four rules make a setting illegal:

- the fetch and write access flags are both set;
- the user access flag and the supervisor-execute guard enable are both set;
- either key restriction flag (access-disable or write-disable) is set while the key enable flag is clear;
- the large-page reserved-bit flag is set while the large-page flag is clear.

The position of each named flag in the vector is a parameter.

The block evaluates at most one increment per clock. While it is passing over illegal settings, its valid output is low. When the count carries out of the top flag, the walk is complete. The block then shows an all-zero vector with its done output high, and stays there until a start pulse begins a new walk.

Top module: `flag_combo_walker`

## Requirements
- R1: While and after reset, `flags_o` is all zeros, `valid_o` is 1 and `done_o` is 0; the all-zero setting is legal.
- R2: Flag i is bit i of `flags_o`. One increment adds one to `flags_o` read as an unsigned binary number: bit 0 is least significant, and each 1 is cleared with the carry moving upward until the first 0 becomes 1.
- R3: No setting shown with `valid_o` high has both bit `IDX_FETCH` and bit `IDX_WRITE` set.
- R4: No setting shown with `valid_o` high has both bit `IDX_USER` and bit `IDX_SXG_EN` set.
- R5: No setting shown with `valid_o` high has bit `IDX_KEY_EN` clear while bit `IDX_KEY_AD` or bit `IDX_KEY_WD` is set.
- R6: No setting shown with `valid_o` high has bit `IDX_LRG_RSV` set while bit `IDX_LRG` is clear.
- R7: An `advance` sampled with `valid_o` high performs one increment at that clock edge. If the result is illegal, the block performs exactly one further increment per clock, with `valid_o` low, until it holds a legal setting. Reaching the next legal setting therefore takes as many clock edges as there are increments.
- R8: An increment that carries out of the top flag ends the walk: `flags_o` becomes all zeros, `valid_o` goes to 0 and `done_o` goes to 1. These values hold until `start`.
- R9: `advance` is ignored while `valid_o` is low, both while skipping and once the walk is done; `flags_o` follows only its own skip sequence.
- R10: `start` at a clock edge returns the block to the all-zero setting with `valid_o` 1 and `done_o` 0, whatever the current state, and takes priority over a simultaneous `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart the walk from the all-zero setting |
| advance | input | 1 | Request the next legal setting; honoured only while `valid_o` is high |
| flags_o | output | NUM_FLAGS | Current flag setting, flag i on bit i |
| valid_o | output | 1 | Current setting is legal and ready for use |
| done_o | output | 1 | Walk complete; all settings have been visited |

## Verification
The bench uses a 10-flag configuration in which each rule flag has its own low position. It walks the complete 1024-setting space from reset to completion. For every step it compares the setting reached, and the number of clock edges taken, against an arithmetic next-legal search. Steps with no skips confirm the plain increment. Steps with long skip runs confirm one increment per clock and show which rule was applied.

The bench also tallies the visited settings per rule, to confirm that no rule was missed or applied too broadly. Requests injected in the middle of skip runs and after completion show that `advance` is ignored while `valid_o` is low. Restarts issued after completion, together with an advance, and in the middle of a walk separate the priority of `start` from normal stepping.

// File: rtl/walker_pkg.sv
package walker_pkg;

    // Walk control states
    typedef enum logic [1:0] {
        WK_READY = 2'd0,   // holding a legal setting, waiting for advance
        WK_SKIP  = 2'd1,   // stepping past illegal settings, one per clock
        WK_DONE  = 2'd2    // counter carried out of the top flag
    } walk_state_e;

    // Result of one increment attempt
    typedef struct packed {
        logic wrapped;     // carry left the top flag
        logic legal;       // incremented setting passes every rule
    } step_info_t;

    // Default flag positions for the 27-flag layout
    localparam int DEF_NUM_FLAGS   = 27;
    localparam int DEF_IDX_LRG     = 12;
    localparam int DEF_IDX_LRG_RSV = 15;
    localparam int DEF_IDX_KEY_AD  = 16;
    localparam int DEF_IDX_KEY_WD  = 17;
    localparam int DEF_IDX_USER    = 19;
    localparam int DEF_IDX_WRITE   = 20;
    localparam int DEF_IDX_FETCH   = 21;
    localparam int DEF_IDX_SXG_EN  = 25;
    localparam int DEF_IDX_KEY_EN  = 26;

    // Next control state from an increment attempt
    function automatic walk_state_e state_after_step(step_info_t s);
        if (s.wrapped)
            return WK_DONE;
        else if (s.legal)
            return WK_READY;
        else
            return WK_SKIP;
    endfunction

endpackage

// File: rtl/flag_incr.sv
module flag_incr #(
    parameter int W = 27
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         carry_out
);
    localparam int CW = W + 1;

    logic [CW-1:0] carry;

    assign carry[0] = 1'b1;

    // Ripple from flag 0 upward: a 0 becomes 1 and stops the carry,
    // a 1 is cleared and passes the carry on.
    for (genvar i = 0; i < W; i++) begin : g_ripple
        assign nxt[i]       = cur[i] ^ carry[i];
        assign carry[i + 1] = carry[i] & cur[i];
    end

    assign carry_out = carry[W];
endmodule

// File: rtl/flag_legality.sv
module flag_legality #(
    parameter int W           = 27,
    parameter int IDX_FETCH   = 21,
    parameter int IDX_WRITE   = 20,
    parameter int IDX_USER    = 19,
    parameter int IDX_SXG_EN  = 25,
    parameter int IDX_KEY_EN  = 26,
    parameter int IDX_KEY_AD  = 16,
    parameter int IDX_KEY_WD  = 17,
    parameter int IDX_LRG     = 12,
    parameter int IDX_LRG_RSV = 15
) (
    input  logic [W-1:0] vec,
    output logic         legal
);
    localparam int NUM_RULES = 4;

    logic [NUM_RULES-1:0] broken;

    always_comb begin
        broken[0] = vec[IDX_FETCH] & vec[IDX_WRITE];
        broken[1] = vec[IDX_USER]  & vec[IDX_SXG_EN];
        broken[2] = ~vec[IDX_KEY_EN] & (vec[IDX_KEY_AD] | vec[IDX_KEY_WD]);
        broken[3] = vec[IDX_LRG_RSV] & ~vec[IDX_LRG];
    end

    assign legal = ~|broken;
endmodule

// File: rtl/flag_combo_walker.sv
module flag_combo_walker
    import walker_pkg::*;
#(
    parameter int NUM_FLAGS   = DEF_NUM_FLAGS,
    parameter int IDX_FETCH   = DEF_IDX_FETCH,
    parameter int IDX_WRITE   = DEF_IDX_WRITE,
    parameter int IDX_USER    = DEF_IDX_USER,
    parameter int IDX_SXG_EN  = DEF_IDX_SXG_EN,
    parameter int IDX_KEY_EN  = DEF_IDX_KEY_EN,
    parameter int IDX_KEY_AD  = DEF_IDX_KEY_AD,
    parameter int IDX_KEY_WD  = DEF_IDX_KEY_WD,
    parameter int IDX_LRG     = DEF_IDX_LRG,
    parameter int IDX_LRG_RSV = DEF_IDX_LRG_RSV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 advance,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 valid_o,
    output logic                 done_o
);
    localparam logic [NUM_FLAGS-1:0] ALL_ZERO = '0;

    walk_state_e          state_q;
    walk_state_e          state_d;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] flags_d;
    logic [NUM_FLAGS-1:0] incr_vec;
    logic                 incr_carry;
    logic                 incr_legal;
    logic                 step_go;
    step_info_t           step_info;

    flag_incr #(
        .W(NUM_FLAGS)
    ) u_incr (
        .cur       (flags_q),
        .nxt       (incr_vec),
        .carry_out (incr_carry)
    );

    flag_legality #(
        .W           (NUM_FLAGS),
        .IDX_FETCH   (IDX_FETCH),
        .IDX_WRITE   (IDX_WRITE),
        .IDX_USER    (IDX_USER),
        .IDX_SXG_EN  (IDX_SXG_EN),
        .IDX_KEY_EN  (IDX_KEY_EN),
        .IDX_KEY_AD  (IDX_KEY_AD),
        .IDX_KEY_WD  (IDX_KEY_WD),
        .IDX_LRG     (IDX_LRG),
        .IDX_LRG_RSV (IDX_LRG_RSV)
    ) u_legal (
        .vec   (incr_vec),
        .legal (incr_legal)
    );

    // An increment happens on a request while ready, or on every clock while skipping.
    assign step_go = ((state_q == WK_READY) && advance) || (state_q == WK_SKIP);

    always_comb begin
        step_info.wrapped = incr_carry;
        step_info.legal   = incr_legal;
        state_d = state_q;
        flags_d = flags_q;
        if (start) begin
            state_d = WK_READY;
            flags_d = ALL_ZERO;
        end else if (step_go) begin
            state_d = state_after_step(step_info);
            flags_d = incr_carry ? ALL_ZERO : incr_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_READY;
            flags_q <= ALL_ZERO;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;
    assign valid_o = (state_q == WK_READY);
    assign done_o  = (state_q == WK_DONE);
endmodule

// File: rtl/walker_props.sv
module walker_props #(
    parameter int NUM_FLAGS   = 27,
    parameter int IDX_FETCH   = 21,
    parameter int IDX_WRITE   = 20,
    parameter int IDX_USER    = 19,
    parameter int IDX_SXG_EN  = 25,
    parameter int IDX_KEY_EN  = 26,
    parameter int IDX_KEY_AD  = 16,
    parameter int IDX_KEY_WD  = 17,
    parameter int IDX_LRG     = 12,
    parameter int IDX_LRG_RSV = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 advance,
    input logic [NUM_FLAGS-1:0] flags_o,
    input logic                 valid_o,
    input logic                 done_o
);
    // R3: a shown setting never pairs fetch with write
    a_r3_no_fetch_write: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !(flags_o[IDX_FETCH] && flags_o[IDX_WRITE]));

    // R4: a shown setting never pairs user access with the execute guard
    a_r4_no_user_guard: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !(flags_o[IDX_USER] && flags_o[IDX_SXG_EN]));

    // R5: key restrictions only appear with key enable
    a_r5_key_needs_enable: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (flags_o[IDX_KEY_EN] || !(flags_o[IDX_KEY_AD] || flags_o[IDX_KEY_WD])));

    // R6: reserved large-page flag only appears with large page
    a_r6_rsv_needs_large: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (flags_o[IDX_LRG] || !flags_o[IDX_LRG_RSV]));

    // R7: apart from restarts, the vector moves by exactly one count per clock
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(rst) && (flags_o != $past(flags_o)))
            |-> (flags_o == NUM_FLAGS'($past(flags_o) + 1'b1)));

    // R8: completion shows zeros and is exclusive with valid
    a_r8_done_zero: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!valid_o && (flags_o == '0)));

    // R8, R9: completion holds until start, regardless of advance
    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start) |=> (done_o && $stable(flags_o)));

    // R10: start returns to the legal zero setting
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (rst)
        start |=> (valid_o && !done_o && (flags_o == '0)));

    // R1: the reset state is visible during reset
    always @(negedge clk) begin
        if (rst && $past(rst)) begin
            a_r1_reset_state: assert (flags_o == '0 && valid_o && !done_o);
        end
    end
endmodule

bind flag_combo_walker walker_props #(
    .NUM_FLAGS   (NUM_FLAGS),
    .IDX_FETCH   (IDX_FETCH),
    .IDX_WRITE   (IDX_WRITE),
    .IDX_USER    (IDX_USER),
    .IDX_SXG_EN  (IDX_SXG_EN),
    .IDX_KEY_EN  (IDX_KEY_EN),
    .IDX_KEY_AD  (IDX_KEY_AD),
    .IDX_KEY_WD  (IDX_KEY_WD),
    .IDX_LRG     (IDX_LRG),
    .IDX_LRG_RSV (IDX_LRG_RSV)
) u_props (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .advance (advance),
    .flags_o (flags_o),
    .valid_o (valid_o),
    .done_o  (done_o)
);

// File: tb/sim_flag_combo_walker.sv
module sim_flag_combo_walker;
    localparam int N       = 10;
    localparam int P_FETCH = 0;
    localparam int P_WRITE = 1;
    localparam int P_USER  = 2;
    localparam int P_SXG   = 3;
    localparam int P_KEN   = 4;
    localparam int P_KAD   = 5;
    localparam int P_KWD   = 6;
    localparam int P_LRG   = 7;
    localparam int P_RSV   = 8;
    localparam int SPACE   = 1 << N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         advance = 1'b0;
    logic [N-1:0] flags_o;
    logic         valid_o;
    logic         done_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    flag_combo_walker #(
        .NUM_FLAGS   (N),
        .IDX_FETCH   (P_FETCH),
        .IDX_WRITE   (P_WRITE),
        .IDX_USER    (P_USER),
        .IDX_SXG_EN  (P_SXG),
        .IDX_KEY_EN  (P_KEN),
        .IDX_KEY_AD  (P_KAD),
        .IDX_KEY_WD  (P_KWD),
        .IDX_LRG     (P_LRG),
        .IDX_LRG_RSV (P_RSV)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .advance (advance),
        .flags_o (flags_o),
        .valid_o (valid_o),
        .done_o  (done_o)
    );

    function automatic bit bit_of(int v, int p);
        return ((v >> p) & 1) != 0;
    endfunction

    function automatic bit model_legal(int v);
        if (bit_of(v, P_FETCH) && bit_of(v, P_WRITE)) return 1'b0;
        if (bit_of(v, P_USER) && bit_of(v, P_SXG)) return 1'b0;
        if (!bit_of(v, P_KEN) && (bit_of(v, P_KAD) || bit_of(v, P_KWD))) return 1'b0;
        if (bit_of(v, P_RSV) && !bit_of(v, P_LRG)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Pulse advance, then count edges until valid or done. Optionally
    // inject a stray advance on the first skip cycle (must be ignored).
    task automatic do_step(bit inject, output int edges);
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        edges = 1;
        if (inject && !valid_o && !done_o) begin
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            edges++;
        end
        while (!valid_o && !done_o && edges < 4 * SPACE) begin
            @(negedge clk);
            edges++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int cur;
        int edges;
        int nxt;
        int legal_seen;
        int legal_expect;
        int viol_r3;
        int viol_r4;
        int viol_r5;
        int viol_r6;
        int rule_r3;
        int rule_r4;
        int rule_r5;
        int rule_r6;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(flags_o == '0 && valid_o && !done_o, "R1 reset", int'(flags_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(flags_o == '0 && valid_o && !done_o, "R1 after reset", int'(flags_o), 0);

        // Exhaustive walk (R2, R3..R6, R7, R9)
        cur = 0;
        legal_seen = 1;
        viol_r3 = 0; viol_r4 = 0; viol_r5 = 0; viol_r6 = 0;
        rule_r3 = 0; rule_r4 = 0; rule_r5 = 0; rule_r6 = 0;
        legal_expect = 0;
        for (int v = 0; v < SPACE; v++) begin
            if (model_legal(v)) legal_expect++;
            if (bit_of(v, P_FETCH) && bit_of(v, P_WRITE)) rule_r3++;
            if (bit_of(v, P_USER) && bit_of(v, P_SXG)) rule_r4++;
            if (!bit_of(v, P_KEN) && (bit_of(v, P_KAD) || bit_of(v, P_KWD))) rule_r5++;
            if (bit_of(v, P_RSV) && !bit_of(v, P_LRG)) rule_r6++;
        end
        while (1) begin
            nxt = cur + 1;
            while (nxt < SPACE && !model_legal(nxt)) nxt++;
            do_step(1'b1, edges);
            if (nxt >= SPACE) begin
                check(edges == nxt - cur, "R7 edges to wrap", edges, nxt - cur);
                break;
            end
            check(valid_o && !done_o && int'(flags_o) == nxt, "R2 next legal setting",
                  int'(flags_o), nxt);
            check(edges == nxt - cur, "R7 one increment per clock", edges, nxt - cur);
            if (flags_o[P_FETCH] && flags_o[P_WRITE]) viol_r3++;
            if (flags_o[P_USER] && flags_o[P_SXG]) viol_r4++;
            if (!flags_o[P_KEN] && (flags_o[P_KAD] || flags_o[P_KWD])) viol_r5++;
            if (flags_o[P_RSV] && !flags_o[P_LRG]) viol_r6++;
            legal_seen++;
            cur = int'(flags_o);
        end
        check(viol_r3 == 0 && rule_r3 > 0, "R3 fetch with write never shown", viol_r3, 0);
        check(viol_r4 == 0 && rule_r4 > 0, "R4 user with guard never shown", viol_r4, 0);
        check(viol_r5 == 0 && rule_r5 > 0, "R5 key flags need enable", viol_r5, 0);
        check(viol_r6 == 0 && rule_r6 > 0, "R6 reserved needs large page", viol_r6, 0);
        check(legal_seen == legal_expect, "R3 R4 R5 R6 legal count", legal_seen, legal_expect);

        // R8: completion state
        check(done_o && !valid_o && flags_o == '0, "R8 done state", int'(done_o), 1);
        repeat (4) @(negedge clk);
        check(done_o && !valid_o && flags_o == '0, "R8 done holds", int'(flags_o), 0);

        // R9: advance while done is ignored
        advance = 1'b1;
        repeat (3) @(negedge clk);
        advance = 1'b0;
        @(negedge clk);
        check(done_o && flags_o == '0, "R9 advance ignored when done", int'(flags_o), 0);

        // R10: start with a simultaneous advance
        start = 1'b1;
        advance = 1'b1;
        @(negedge clk);
        start = 1'b0;
        advance = 1'b0;
        check(valid_o && !done_o && flags_o == '0, "R10 start beats advance",
              int'(flags_o), 0);

        // Walk a few steps, then restart mid-walk
        cur = 0;
        for (int k = 0; k < 6; k++) begin
            nxt = cur + 1;
            while (!model_legal(nxt)) nxt++;
            do_step(1'b0, edges);
            check(int'(flags_o) == nxt && edges == nxt - cur, "R2 second walk",
                  int'(flags_o), nxt);
            cur = nxt;
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(valid_o && !done_o && flags_o == '0, "R10 mid-walk restart", int'(flags_o), 0);
        do_step(1'b0, edges);
        check(int'(flags_o) == 1 && valid_o && edges == 1, "R2 first step after restart",
              int'(flags_o), 1);

        summary();
    end
endmodule